// File: doc/BRIEF.md
# Descriptor-Driven I/O Channel Engine

This block takes over word transfers between one peripheral handshake port and system memory. Software writes the byte address of a command list into a register and then issues a start command. From then on the engine works alone. It reads four-word descriptors from memory, decodes each one, and moves data in the direction the descriptor names. It gets each memory cycle through a request/grant pair, so it only ever uses cycles the memory side agrees to give up. When the list ends, or when an illegal command is found, it raises an interrupt that stays high until software acknowledges it.

The sequencer has these states. IDLE waits for start. FETCH requests one descriptor word. FETCH_GAP drops the request for one cycle between descriptor words. DECODE picks the transfer path. RX_WAIT accepts a word from the device. MEM_WR writes that word to memory. MEM_RD reads a word from memory. TX_SEND offers that word to the device. DESC_END retires the descriptor. FAULT reports an illegal opcode.

The transitions are:
- start: IDLE to FETCH.
- word granted: FETCH to FETCH_GAP.
- gap done: FETCH_GAP to FETCH.
- fourth word granted: FETCH to DECODE.
- inbound: DECODE to RX_WAIT.
- outbound: DECODE to MEM_RD.
- empty or no-op: DECODE to DESC_END.
- bad opcode: DECODE to FAULT.
- device word taken: RX_WAIT to MEM_WR.
- write granted: MEM_WR to RX_WAIT, or to DESC_END on the final word.
- read granted: MEM_RD to TX_SEND.
- device accepted: TX_SEND to MEM_RD, or to DESC_END on the final word.
- chain: DESC_END to FETCH.
- list end: DESC_END to IDLE.
- fault return: FAULT to IDLE.

Top module: `chan_engine`

## Requirements
- R1: After reset these all read 0: the status register, the current-descriptor register, `irq`, `mem_req`, `dev_rx_ready` and `dev_tx_valid`.
- R2: A write to register index 1 with data bit 0 set starts the engine from the list base when the engine is idle. Status bit 0 (busy) then reads 1. The same write while busy has no effect.
- R3: A descriptor is four words at consecutive word addresses: ptr, ptr+4, ptr+8 and ptr+12. Word 0 holds the opcode in bits [3:0] and the device id in bits [7:4]. Word 1 is the buffer byte address. Word 2 is the byte count. Word 3 holds the flags: bit 0 means last, bit 1 means interrupt. The next descriptor starts at ptr+16. Register index 3 and `dev_id` show the current descriptor and its device.
- R4: `mem_req` stays high, with stable address and direction, until `mem_gnt`. Exactly one word moves in the grant cycle: read data is taken from `mem_rdata`, or a write happens. `mem_req` is low in the next cycle. One descriptor costs four grants plus one grant per data word.
- R5: Opcode 1 moves data from the device to memory. A word is taken on a cycle with `dev_rx_valid` and `dev_rx_ready` both high. Words are written from the buffer address upward in steps of 4. The engine moves ceil(count/4) words and no more.
- R6: Opcode 2 moves data from memory to the device. Words are read from the buffer address upward. Each word is held on `dev_tx_data` with `dev_tx_valid` high until `dev_tx_ready`. The engine moves ceil(count/4) words.
- R7: Opcode 0, or a byte count of 0, retires the descriptor with no device handshake and no data grant.
- R8: An opcode from 3 to 15 stops the engine after the fetch. It sets status bit 2 (error) and bit 1 (done), and raises `irq`. The next start clears the error bit.
- R9: When a descriptor with the last flag retires, busy clears and done sets. `irq` is high in the first cycle in which busy reads 0.
- R10: When a descriptor that has the interrupt flag but not the last flag retires, done and `irq` are set and the engine goes on to the next descriptor.
- R11: `irq` follows the done bit. It falls only after a write to register index 2 with data bit 1 set. Writing 0 there leaves it high. A new event in the same cycle as the clear wins over the clear.
- R12: The register map is: index 0, list base (read/write); index 1, control (write-only, reads 0); index 2, status; index 3, current-descriptor address (read-only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt, level |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory grant; the access completes in this cycle |
| mem_rdata | input | 32 | Memory read data, valid in the grant cycle |
| dev_id | output | 4 | Device id of the current descriptor |
| dev_rx_valid | input | 1 | Device has an inbound word |
| dev_rx_ready | output | 1 | Engine accepts an inbound word |
| dev_rx_data | input | 32 | Inbound word |
| dev_tx_valid | output | 1 | Engine offers an outbound word |
| dev_tx_ready | input | 1 | Device accepts the outbound word |
| dev_tx_data | output | 32 | Outbound word |

## Verification
The memory-port checks assume three things. `mem_gnt` only answers a pending `mem_req`. A grant lasts one cycle. Read data is valid in that same cycle.

The outbound hold check assumes the device raises `dev_tx_ready` only after it sees `dev_tx_valid`. The bench memory model raises a grant only after it counts a programmed delay against a request that is still pending, and drops the grant at once. Its device models raise ready or valid only after a programmed delay and clear them after each handshake.

Register writes are made only when the intended effect is defined. The one exception is the start written on purpose during a running list.

// File: rtl/chan_pkg.sv
`timescale 1ns/1ps
package chan_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_FETCH,
        S_FETCH_GAP,
        S_DECODE,
        S_RX_WAIT,
        S_MEM_WR,
        S_MEM_RD,
        S_TX_SEND,
        S_DESC_END,
        S_FAULT
    } seq_state_e;

    // register indices
    localparam logic [1:0] REG_BASE = 2'd0;
    localparam logic [1:0] REG_CTRL = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;
    localparam logic [1:0] REG_CUR  = 2'd3;

    // status bit positions
    localparam int STAT_BUSY = 0;
    localparam int STAT_DONE = 1;
    localparam int STAT_ERR  = 2;

    // opcodes
    localparam int OPC_NOP     = 0;
    localparam int OPC_DEV2MEM = 1;
    localparam int OPC_MEM2DEV = 2;

    // descriptor shape
    localparam int DESC_WORDS = 4;
    localparam int FLAG_LAST  = 0;
    localparam int FLAG_IRQ   = 1;

endpackage

// File: rtl/chan_regs.sv
`timescale 1ns/1ps
module chan_regs
    import chan_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         busy,
    input  logic [W-1:0] cur_desc,
    input  logic         ev_set,
    input  logic         err_set,
    output logic         start_pulse,
    output logic [W-1:0] list_base,
    output logic         irq
);

    localparam int STAT_W = STAT_ERR + 1;

    logic         done_q;
    logic         err_q;
    logic [W-1:0] base_q;
    logic         done_clr;

    assign start_pulse = reg_wr && (reg_addr == REG_CTRL) && reg_wdata[0] && !busy;
    assign done_clr    = reg_wr && (reg_addr == REG_STAT) && reg_wdata[STAT_DONE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (reg_wr && (reg_addr == REG_BASE)) begin
                base_q <= reg_wdata;
            end
            // a new event wins over a same-cycle clear
            if (ev_set) begin
                done_q <= 1'b1;
            end else if (done_clr) begin
                done_q <= 1'b0;
            end
            if (err_set) begin
                err_q <= 1'b1;
            end else if (start_pulse) begin
                err_q <= 1'b0;
            end
        end
    end

    logic [STAT_W-1:0] stat_bits;
    always_comb begin
        stat_bits            = '0;
        stat_bits[STAT_BUSY] = busy;
        stat_bits[STAT_DONE] = done_q;
        stat_bits[STAT_ERR]  = err_q;
    end

    always_comb begin
        unique case (reg_addr)
            REG_BASE: reg_rdata = base_q;
            REG_CTRL: reg_rdata = '0;
            REG_STAT: reg_rdata = W'(stat_bits);
            REG_CUR:  reg_rdata = cur_desc;
            default:  reg_rdata = '0;
        endcase
    end

    assign list_base = base_q;
    assign irq       = done_q;

    // the interrupt drops only after an acknowledge write
    assert_irq_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_wr && (reg_addr == REG_STAT) && reg_wdata[STAT_DONE]));

    // the interrupt rises only after the sequencer reported an event
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ev_set));

endmodule

// File: rtl/chan_seq.sv
`timescale 1ns/1ps
module chan_seq
    import chan_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEV_W = 4,
    parameter int OP_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     list_base,
    output logic             busy,
    output logic [W-1:0]     cur_desc,
    output logic             ev_set,
    output logic             err_set,
    output logic             mem_req,
    output logic             mem_we,
    output logic [W-1:0]     mem_addr,
    output logic [W-1:0]     mem_wdata,
    input  logic             mem_gnt,
    input  logic [W-1:0]     mem_rdata,
    output logic [DEV_W-1:0] dev_id,
    input  logic             rx_valid,
    output logic             rx_ready,
    input  logic [W-1:0]     rx_data,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [W-1:0]     tx_data
);

    localparam int           WCNT_W     = W - 1;
    localparam int           IDX_W      = $clog2(DESC_WORDS);
    localparam logic [W-1:0] WORD_STEP  = W'(4);
    localparam logic [W-1:0] DESC_STEP  = W'(DESC_WORDS * 4);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

    seq_state_e state_q, state_d;

    logic [W-1:0]      desc_ptr_q;
    logic [W-1:0]      buf_addr_q;
    logic [W-1:0]      xfer_q;
    logic [IDX_W-1:0]  widx_q;
    logic [OP_W-1:0]   op_q;
    logic [DEV_W-1:0]  dev_q;
    logic [WCNT_W-1:0] left_q;
    logic [WCNT_W-1:0] words_from_cnt;
    logic              last_q;
    logic              irqf_q;
    logic              grant;
    logic              left_one;
    logic              left_zero;

    assign grant          = mem_req && mem_gnt;
    assign words_from_cnt = {1'b0, mem_rdata[W-1:2]} + WCNT_W'(|mem_rdata[1:0]);
    assign left_one       = (left_q == WCNT_W'(1));
    assign left_zero      = (left_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) state_d = S_FETCH;
            end
            S_FETCH: begin
                if (grant) state_d = (widx_q == IDX_LAST) ? S_DECODE : S_FETCH_GAP;
            end
            S_FETCH_GAP: begin
                state_d = S_FETCH;
            end
            S_DECODE: begin
                if (op_q == OP_W'(OPC_NOP)) begin
                    state_d = S_DESC_END;
                end else if (op_q == OP_W'(OPC_DEV2MEM)) begin
                    state_d = left_zero ? S_DESC_END : S_RX_WAIT;
                end else if (op_q == OP_W'(OPC_MEM2DEV)) begin
                    state_d = left_zero ? S_DESC_END : S_MEM_RD;
                end else begin
                    state_d = S_FAULT;
                end
            end
            S_RX_WAIT: begin
                if (rx_valid) state_d = S_MEM_WR;
            end
            S_MEM_WR: begin
                if (grant) state_d = left_one ? S_DESC_END : S_RX_WAIT;
            end
            S_MEM_RD: begin
                if (grant) state_d = S_TX_SEND;
            end
            S_TX_SEND: begin
                if (tx_ready) state_d = left_one ? S_DESC_END : S_MEM_RD;
            end
            S_DESC_END: begin
                state_d = last_q ? S_IDLE : S_FETCH;
            end
            S_FAULT: begin
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_ptr_q <= '0;
            buf_addr_q <= '0;
            xfer_q     <= '0;
            widx_q     <= '0;
            op_q       <= '0;
            dev_q      <= '0;
            left_q     <= '0;
            last_q     <= 1'b0;
            irqf_q     <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        desc_ptr_q <= list_base;
                        widx_q     <= '0;
                    end
                end
                S_FETCH: begin
                    if (grant) begin
                        widx_q <= widx_q + IDX_W'(1);
                        unique case (widx_q)
                            IDX_W'(0): begin
                                op_q  <= mem_rdata[OP_W-1:0];
                                dev_q <= mem_rdata[OP_W +: DEV_W];
                            end
                            IDX_W'(1): buf_addr_q <= mem_rdata;
                            IDX_W'(2): left_q     <= words_from_cnt;
                            default: begin
                                last_q <= mem_rdata[FLAG_LAST];
                                irqf_q <= mem_rdata[FLAG_IRQ];
                            end
                        endcase
                    end
                end
                S_RX_WAIT: begin
                    if (rx_valid) xfer_q <= rx_data;
                end
                S_MEM_WR: begin
                    if (grant) begin
                        buf_addr_q <= buf_addr_q + WORD_STEP;
                        left_q     <= left_q - WCNT_W'(1);
                    end
                end
                S_MEM_RD: begin
                    if (grant) xfer_q <= mem_rdata;
                end
                S_TX_SEND: begin
                    if (tx_ready) begin
                        buf_addr_q <= buf_addr_q + WORD_STEP;
                        left_q     <= left_q - WCNT_W'(1);
                    end
                end
                S_DESC_END: begin
                    if (!last_q) begin
                        desc_ptr_q <= desc_ptr_q + DESC_STEP;
                        widx_q     <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        rx_ready = 1'b0;
        tx_valid = 1'b0;
        ev_set   = 1'b0;
        err_set  = 1'b0;
        unique case (state_q)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = desc_ptr_q + W'({widx_q, 2'b00});
            end
            S_RX_WAIT: rx_ready = 1'b1;
            S_MEM_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = buf_addr_q;
            end
            S_MEM_RD: begin
                mem_req  = 1'b1;
                mem_addr = buf_addr_q;
            end
            S_TX_SEND: tx_valid = 1'b1;
            S_DESC_END: ev_set = last_q || irqf_q;
            S_FAULT: begin
                ev_set  = 1'b1;
                err_set = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy      = (state_q != S_IDLE);
    assign cur_desc  = desc_ptr_q;
    assign dev_id    = dev_q;
    assign mem_wdata = xfer_q;
    assign tx_data   = xfer_q;

    // a pending request holds its address and direction
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // one access per grant, then the request is released
    assert_req_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_gnt |=> !mem_req);

    // an offered outbound word stays put until accepted
    assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // a write to memory carries the word last taken from the device
    assert_wr_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready |=> mem_req && mem_we && (mem_wdata == $past(rx_data)));

endmodule

// File: rtl/chan_engine.sv
`timescale 1ns/1ps
module chan_engine
    import chan_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEV_W = 4,
    parameter int OP_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [W-1:0]     reg_wdata,
    output logic [W-1:0]     reg_rdata,
    output logic             irq,
    output logic             mem_req,
    output logic             mem_we,
    output logic [W-1:0]     mem_addr,
    output logic [W-1:0]     mem_wdata,
    input  logic             mem_gnt,
    input  logic [W-1:0]     mem_rdata,
    output logic [DEV_W-1:0] dev_id,
    input  logic             dev_rx_valid,
    output logic             dev_rx_ready,
    input  logic [W-1:0]     dev_rx_data,
    output logic             dev_tx_valid,
    input  logic             dev_tx_ready,
    output logic [W-1:0]     dev_tx_data
);

    logic         seq_busy;
    logic [W-1:0] seq_cur;
    logic         seq_ev;
    logic         seq_err;
    logic         start_pulse;
    logic [W-1:0] list_base;

    chan_regs #(.W(W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .busy        (seq_busy),
        .cur_desc    (seq_cur),
        .ev_set      (seq_ev),
        .err_set     (seq_err),
        .start_pulse (start_pulse),
        .list_base   (list_base),
        .irq         (irq)
    );

    chan_seq #(.W(W), .DEV_W(DEV_W), .OP_W(OP_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_pulse),
        .list_base (list_base),
        .busy      (seq_busy),
        .cur_desc  (seq_cur),
        .ev_set    (seq_ev),
        .err_set   (seq_err),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_gnt   (mem_gnt),
        .mem_rdata (mem_rdata),
        .dev_id    (dev_id),
        .rx_valid  (dev_rx_valid),
        .rx_ready  (dev_rx_ready),
        .rx_data   (dev_rx_data),
        .tx_valid  (dev_tx_valid),
        .tx_ready  (dev_tx_ready),
        .tx_data   (dev_tx_data)
    );

    // list end leaves the interrupt raised as busy drops
    assert_finish_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_busy) |-> irq);

    // a fault stops the sequencer and raises the interrupt
    assert_fault_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> !seq_busy && irq);

endmodule

// File: tb/chan_engine_bench.sv
`timescale 1ns/1ps
module chan_engine_bench;

    localparam int NV = 10;

    typedef struct packed {
        logic [3:0]  op;
        logic [11:0] count;
        logic [3:0]  gdly;
        logic [3:0]  ddly;
        logic [31:0] seed;
        logic        exp_err;
        logic [7:0]  exp_words;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{op: 4'd1,  count: 12'd16, gdly: 4'd0, ddly: 4'd0, seed: 32'h1000_0000, exp_err: 1'b0, exp_words: 8'd4},
        '{op: 4'd1,  count: 12'd7,  gdly: 4'd2, ddly: 4'd1, seed: 32'h2000_0100, exp_err: 1'b0, exp_words: 8'd2},
        '{op: 4'd2,  count: 12'd12, gdly: 4'd0, ddly: 4'd0, seed: 32'h0,         exp_err: 1'b0, exp_words: 8'd3},
        '{op: 4'd2,  count: 12'd5,  gdly: 4'd3, ddly: 4'd2, seed: 32'h0,         exp_err: 1'b0, exp_words: 8'd2},
        '{op: 4'd1,  count: 12'd0,  gdly: 4'd1, ddly: 4'd0, seed: 32'h4000_0000, exp_err: 1'b0, exp_words: 8'd0},
        '{op: 4'd0,  count: 12'd8,  gdly: 4'd0, ddly: 4'd0, seed: 32'h4100_0000, exp_err: 1'b0, exp_words: 8'd0},
        '{op: 4'd9,  count: 12'd4,  gdly: 4'd1, ddly: 4'd0, seed: 32'h4200_0000, exp_err: 1'b1, exp_words: 8'd0},
        '{op: 4'd2,  count: 12'd0,  gdly: 4'd0, ddly: 4'd0, seed: 32'h0,         exp_err: 1'b0, exp_words: 8'd0},
        '{op: 4'd15, count: 12'd4,  gdly: 4'd0, ddly: 4'd0, seed: 32'h0,         exp_err: 1'b1, exp_words: 8'd0},
        '{op: 4'd1,  count: 12'd13, gdly: 4'd1, ddly: 4'd3, seed: 32'h3000_0000, exp_err: 1'b0, exp_words: 8'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_gnt = 1'b0;
    logic [3:0]  dev_id;
    logic        dev_rx_valid = 1'b0;
    logic        dev_rx_ready;
    logic [31:0] dev_rx_data;
    logic        dev_tx_valid;
    logic        dev_tx_ready = 1'b0;
    logic [31:0] dev_tx_data;

    // bench model controls
    logic        tb_we = 1'b0;
    logic [5:0]  tb_wa = '0;
    logic [31:0] tb_wd = '0;
    logic        tb_clr = 1'b0;
    logic [3:0]  gdly = '0;
    logic [3:0]  ddly = '0;
    logic [31:0] seed = '0;

    logic [31:0] mem [64];
    logic [3:0]  gcnt = '0;
    int          grant_cnt = 0;
    logic [3:0]  rcnt = '0;
    int          rx_idx = 0;
    logic [3:0]  tcnt = '0;
    int          tx_cnt = 0;
    logic [31:0] tx_log [16];
    logic [3:0]  last_dev = '0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    chan_engine u_chan_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .irq          (irq),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_gnt      (mem_gnt),
        .mem_rdata    (mem_rdata),
        .dev_id       (dev_id),
        .dev_rx_valid (dev_rx_valid),
        .dev_rx_ready (dev_rx_ready),
        .dev_rx_data  (dev_rx_data),
        .dev_tx_valid (dev_tx_valid),
        .dev_tx_ready (dev_tx_ready),
        .dev_tx_data  (dev_tx_data)
    );

    assign mem_rdata   = mem[mem_addr[7:2]];
    assign dev_rx_data = seed + 32'(rx_idx);

    // memory with delayed one-cycle grant
    always @(posedge clk) begin
        if (tb_we) begin
            mem[tb_wa] <= tb_wd;
        end else if (mem_req && mem_gnt && mem_we) begin
            mem[mem_addr[7:2]] <= mem_wdata;
        end
        if (tb_clr) begin
            mem_gnt   <= 1'b0;
            gcnt      <= '0;
            grant_cnt <= 0;
        end else if (mem_req && !mem_gnt) begin
            if (gcnt >= gdly) mem_gnt <= 1'b1;
            else gcnt <= gcnt + 4'd1;
        end else begin
            if (mem_req && mem_gnt) grant_cnt <= grant_cnt + 1;
            mem_gnt <= 1'b0;
            gcnt    <= '0;
        end
    end

    // inbound device source and outbound device sink
    always @(posedge clk) begin
        if (tb_clr) begin
            dev_rx_valid <= 1'b0;
            rcnt         <= '0;
            rx_idx       <= 0;
            dev_tx_ready <= 1'b0;
            tcnt         <= '0;
            tx_cnt       <= 0;
            last_dev     <= 4'hF;
        end else begin
            if (dev_rx_valid && dev_rx_ready) begin
                dev_rx_valid <= 1'b0;
                rcnt         <= '0;
                rx_idx       <= rx_idx + 1;
                last_dev     <= dev_id;
            end else if (!dev_rx_valid) begin
                if (rcnt >= ddly) dev_rx_valid <= 1'b1;
                else rcnt <= rcnt + 4'd1;
            end
            if (dev_tx_valid && dev_tx_ready) begin
                tx_log[tx_cnt[3:0]] <= dev_tx_data;
                tx_cnt              <= tx_cnt + 1;
                dev_tx_ready        <= 1'b0;
                tcnt                <= '0;
                last_dev            <= dev_id;
            end else if (dev_tx_valid && !dev_tx_ready) begin
                if (tcnt >= ddly) dev_tx_ready <= 1'b1;
                else tcnt <= tcnt + 4'd1;
            end
        end
    end

    function automatic logic [31:0] pat(input int v, input int k);
        return 32'hA500_0000 | 32'(v << 8) | 32'(k);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic poke(input int idx, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_wa = 6'(idx); tb_wd = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic clear_models();
        @(negedge clk);
        tb_clr = 1'b1;
        @(negedge clk);
        tb_clr = 1'b0;
    endtask

    task automatic wait_irq(input int lim, output bit seen);
        seen = 1'b0;
        for (int c = 0; c < lim && !seen; c++) begin
            @(negedge clk);
            if (irq) seen = 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        bit          seen;
        vec_t        v;
        int          n;

        for (int k = 0; k < 64; k++) mem[k] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        clear_models();

        // R1: reset state
        reg_read(REG_STAT_IDX(), rd);
        check(rd == 32'h0, "R1 status", rd, 32'h0);
        reg_read(2'd3, rd);
        check(rd == 32'h0, "R1 cur", rd, 32'h0);
        check({irq, mem_req, dev_rx_ready, dev_tx_valid} == 4'b0, "R1 outputs",
              32'({irq, mem_req, dev_rx_ready, dev_tx_valid}), 32'h0);

        // R12: list base readback, control reads zero
        reg_write(2'd0, 32'h40);
        reg_read(2'd0, rd);
        check(rd == 32'h40, "R12 base", rd, 32'h40);
        reg_read(2'd1, rd);
        check(rd == 32'h0, "R12 ctrl", rd, 32'h0);

        // vector table: single-descriptor lists
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            n = int'(v.exp_words);
            gdly = v.gdly; ddly = v.ddly; seed = v.seed;
            clear_models();
            poke(16, {24'h0, 4'(i), v.op});
            poke(17, 32'h80);
            poke(18, {20'h0, v.count});
            poke(19, 32'h1);
            for (int k = 0; k < 16; k++) poke(32 + k, pat(i, k));
            reg_write(2'd0, 32'h40);
            reg_write(2'd1, 32'h1);
            wait_irq(3000, seen);
            check(seen, "R9 irq", 32'(seen), 32'h1);
            reg_read(2'd2, rd);
            if (v.exp_err)
                check(rd == 32'h6, "R8 status", rd, 32'h6);
            else
                check(rd == 32'h2, "R9 status", rd, 32'h2);
            check(grant_cnt == 4 + n, "R4 grants", 32'(grant_cnt), 32'(4 + n));
            reg_read(2'd3, rd);
            check(rd == 32'h40, "R3 cur", rd, 32'h40);
            if (v.op == 4'd1) begin
                check(rx_idx == n, "R5 words", 32'(rx_idx), 32'(n));
                for (int k = 0; k < n; k++)
                    check(mem[32 + k] == seed + 32'(k), "R5 data", mem[32 + k], seed + 32'(k));
                check(mem[32 + n] == pat(i, n), "R5 bound", mem[32 + n], pat(i, n));
            end
            if (v.op == 4'd2) begin
                check(tx_cnt == n, "R6 words", 32'(tx_cnt), 32'(n));
                for (int k = 0; k < n; k++)
                    check(tx_log[k] == pat(i, k), "R6 data", tx_log[k], pat(i, k));
            end
            if (n == 0)
                check(rx_idx == 0 && tx_cnt == 0, "R7 no data", 32'(rx_idx + tx_cnt), 32'h0);
            else
                check(last_dev == 4'(i), "R3 dev", 32'(last_dev), 32'(i));
            reg_write(2'd2, 32'h2);
            check(irq == 1'b0, "R11 ack", 32'(irq), 32'h0);
        end

        // directed: two-descriptor chain with mid-list interrupt
        gdly = 4'd1; ddly = 4'd1; seed = 32'h5500_0000;
        clear_models();
        poke(16, 32'h0000_0031); poke(17, 32'h80); poke(18, 32'd8); poke(19, 32'h2);
        poke(20, 32'h0000_0052); poke(21, 32'hC0); poke(22, 32'd8); poke(23, 32'h1);
        poke(48, 32'hB000_0000); poke(49, 32'hB000_0001);
        poke(32, 32'h0); poke(33, 32'h0);
        reg_write(2'd0, 32'h40);
        reg_write(2'd1, 32'h1);
        reg_read(2'd2, rd);
        check(rd[0] == 1'b1, "R2 busy", rd, 32'h1);
        reg_write(2'd1, 32'h1);   // ignored while busy
        wait_irq(3000, seen);
        check(seen, "R10 irq", 32'(seen), 32'h1);
        reg_read(2'd2, rd);
        check(rd == 32'h3, "R10 still busy", rd, 32'h3);
        reg_read(2'd3, rd);
        check(rd == 32'h50, "R3 next desc", rd, 32'h50);
        reg_write(2'd2, 32'h0);
        check(irq == 1'b1, "R11 write zero", 32'(irq), 32'h1);
        reg_write(2'd2, 32'h2);
        check(irq == 1'b0, "R11 clear", 32'(irq), 32'h0);
        wait_irq(3000, seen);
        check(seen, "R9 chain irq", 32'(seen), 32'h1);
        reg_read(2'd2, rd);
        check(rd == 32'h2, "R9 chain status", rd, 32'h2);
        check(rx_idx == 2, "R2 restart ignored", 32'(rx_idx), 32'h2);
        check(mem[32] == 32'h5500_0000 && mem[33] == 32'h5500_0001, "R5 chain data",
              mem[33], 32'h5500_0001);
        check(tx_cnt == 2 && tx_log[0] == 32'hB000_0000 && tx_log[1] == 32'hB000_0001,
              "R6 chain data", tx_log[1], 32'hB000_0001);
        check(last_dev == 4'd5, "R3 chain dev", 32'(last_dev), 32'h5);
        check(grant_cnt == 12, "R4 chain grants", 32'(grant_cnt), 32'd12);
        reg_read(2'd3, rd);
        check(rd == 32'h50, "R3 chain cur", rd, 32'h50);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    function automatic logic [1:0] REG_STAT_IDX();
        return 2'd2;
    endfunction

endmodule